// File: doc/BRIEF.md
# Page-Group Protected Memory Copy Unit

This unit commits a full 32-byte scratchpad image into one page of an 80-page non-volatile array. The array is modelled here as synchronous byte-wide RAM. The pages are split into ten protection groups of eight consecutive pages. Each group holds one of three modes:
- open, where the new data simply replaces the stored data;
- locked, where no stored bit may ever change;
- erase-free, where a stored bit may only fall from 1 to 0. The stored result is the old byte ANDed with the new byte.

A copy request is offered on a valid/ready handshake and carries a target address and the 256-bit scratchpad image. The page index comes from address bits [11:5]. The low five bits play no part, because the whole page is always written. For an accepted copy the unit reads each old byte, merges it with the new byte according to the group mode, and writes it back, one byte per clock. It then pulses `done`. A copy into a locked group, or into a page index outside the array, is refused. A refused copy writes nothing and pulses `done` together with `err`.

Back-pressure: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a copy runs, `req_ready` stays low and the offered request is not consumed. A source that drops `req_valid` before the unit is idle again loses nothing that was acted upon. Group modes are set through plain control pins, and a mode other than open is sticky until reset. A byte read port lets the array be inspected while the unit is idle.

Top module: `pgcopy_unit`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, `req_ready` is 1 and every group is open.
- R2: `req_ready` equals not-busy. A request offered while busy is not accepted, and neither its page nor the running copy is affected by it.
- R3: The page index is `req_addr[11:5]` and the low five address bits are ignored. Byte k of the page (k = 0..31) is taken from `req_data[8k+7:8k]`.
- R4: In an open group, every byte of the target page becomes the new byte.
- R5: In a locked group, a copy changes no stored bit. `done` and `err` are both high for exactly the one cycle after acceptance, and `busy` never rises.
- R6: In an erase-free group, each stored byte becomes the old byte AND the new byte, so no bit ever goes from 0 to 1.
- R7: A target page index of 80 or above is refused in the same way as a locked group.
- R8: Mode codes on `mode_set_val` are 00 open, 01 locked, 10 erase-free; code 11 is ignored. `mode_set_grp` selects group = page index / 8, and the new mode applies to copies accepted from the next cycle on.
- R9: A mode change is ignored when the selected group is already locked or erase-free.
- R10: An accepted copy keeps `busy` high for exactly 33 cycles. `done` is high, with `err` low, for exactly the one cycle after `busy` falls.
- R11: While idle, `rd_data` returns, one cycle later, the byte at `rd_addr` = {page index, byte offset}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | 12 | Target address; bits [11:5] give the page |
| req_data | input | 256 | Scratchpad image; byte k in bits [8k+7:8k] |
| mode_set_en | input | 1 | Apply a mode change this cycle |
| mode_set_grp | input | 4 | Protection group to change |
| mode_set_val | input | 2 | New mode code |
| rd_addr | input | 12 | Inspection address {page, offset} |
| rd_data | output | 8 | Byte read one cycle after `rd_addr` |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when a copy ends or is refused |
| err | output | 1 | One-cycle pulse with `done` when a copy is refused |

## Verification
Copies are tried in open pages with two successive, unrelated images, so that both 0-to-1 and 1-to-0 changes show up; a stale byte or a wrong byte lane would be caught. Erase-free pages get two successive images over a known pattern, which separates an AND merge from both overwrite and OR. Locked, out-of-range and mode-change-rejected cases each target pages with known contents, so a refusal that still writes is caught. A request held during a busy copy, aimed at a different pre-written page, separates a unit that ignores it from one that restarts or queues it.

// File: rtl/pgcopy_pkg.sv
package pgcopy_pkg;

  typedef enum logic [1:0] {
    GM_OPEN = 2'b00,
    GM_LOCK = 2'b01,
    GM_EMUL = 2'b10,
    GM_RSVD = 2'b11
  } grp_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } copy_state_e;

endpackage

// File: rtl/pgcopy_grp_modes.sv
module pgcopy_grp_modes
  import pgcopy_pkg::*;
#(
  parameter int NUM_GRPS = 10,
  parameter int GRP_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  logic [GRP_W-1:0]             set_grp,
  input  logic [1:0]                   set_val,
  output logic [NUM_GRPS-1:0][1:0]     modes_o
);

  logic val_ok;
  assign val_ok = (set_val == GM_LOCK) || (set_val == GM_EMUL);

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    logic [1:0] mode_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_r <= GM_OPEN;
      end else if (set_en && (set_grp == GRP_W'(g)) && (mode_r == GM_OPEN) && val_ok) begin
        mode_r <= set_val;
      end
    end
    assign modes_o[g] = mode_r;
  end

endmodule

// File: rtl/pgcopy_ram.sv
module pgcopy_ram #(
  parameter int DEPTH = 2560,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
    rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
  end

endmodule

// File: rtl/pgcopy_merge.sv
module pgcopy_merge
  import pgcopy_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] old_byte,
  input  logic [W-1:0] new_byte,
  output logic [W-1:0] out_byte
);

  always_comb begin
    if (mode == GM_EMUL) out_byte = old_byte & new_byte;
    else                 out_byte = new_byte;
  end

endmodule

// File: rtl/pgcopy_unit.sv
module pgcopy_unit
  import pgcopy_pkg::*;
#(
  parameter int NUM_PAGES     = 80,
  parameter int PAGE_BYTES    = 32,
  parameter int PAGES_PER_GRP = 8,
  localparam int OFS_W    = $clog2(PAGE_BYTES),
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int MEM_AW   = PG_W + OFS_W,
  localparam int DATA_W   = PAGE_BYTES * 8,
  localparam int NUM_GRPS = NUM_PAGES / PAGES_PER_GRP,
  localparam int GRP_W    = $clog2(NUM_GRPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              mode_set_en,
  input  logic [GRP_W-1:0]  mode_set_grp,
  input  logic [1:0]        mode_set_val,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int CNT_W = OFS_W + 1;

  copy_state_e              state;
  logic [CNT_W-1:0]         cnt;
  logic [PG_W-1:0]          pg_q;
  logic [DATA_W-1:0]        data_q;
  grp_mode_e                mode_q;
  logic [NUM_GRPS-1:0][1:0] modes;

  logic [PG_W-1:0]  req_page;
  logic [GRP_W-1:0] req_grp;
  logic             in_range;
  grp_mode_e        acc_mode;
  logic             refuse;
  logic             accept;
  logic             unused_ofs;

  logic              ram_we;
  logic [MEM_AW-1:0] ram_waddr;
  logic [MEM_AW-1:0] ram_raddr;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata;
  logic [7:0]        new_byte;
  logic [OFS_W-1:0]  wr_ofs;

  // Request decode
  assign req_page   = req_addr[MEM_AW-1:OFS_W];
  assign req_grp    = GRP_W'(req_page / PG_W'(PAGES_PER_GRP));
  assign in_range   = req_page < PG_W'(NUM_PAGES);
  assign unused_ofs = ^req_addr[OFS_W-1:0];

  always_comb begin
    acc_mode = GM_LOCK;
    for (int g = 0; g < NUM_GRPS; g++) begin
      if (in_range && (req_grp == GRP_W'(g))) acc_mode = grp_mode_e'(modes[g]);
    end
  end

  assign refuse    = (acc_mode == GM_LOCK);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (state == ST_RUN);

  // Sequencer: one read and one write per cycle, write trails read by one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      pg_q   <= '0;
      data_q <= '0;
      mode_q <= GM_OPEN;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (refuse) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              state  <= ST_RUN;
              cnt    <= '0;
              pg_q   <= req_page;
              data_q <= req_data;
              mode_q <= acc_mode;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PAGE_BYTES)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_ofs    = OFS_W'(cnt - 1'b1);
  assign new_byte  = data_q[wr_ofs*8 +: 8];
  assign ram_we    = busy && (cnt != '0);
  assign ram_waddr = {pg_q, wr_ofs};
  assign ram_raddr = busy ? {pg_q, cnt[OFS_W-1:0]} : rd_addr;
  assign rd_data   = ram_rdata;

  pgcopy_grp_modes #(
    .NUM_GRPS (NUM_GRPS),
    .GRP_W    (GRP_W)
  ) u_modes (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (mode_set_en),
    .set_grp (mode_set_grp),
    .set_val (mode_set_val),
    .modes_o (modes)
  );

  pgcopy_merge #(
    .W (8)
  ) u_merge (
    .mode     (mode_q),
    .old_byte (ram_rdata),
    .new_byte (new_byte),
    .out_byte (ram_wdata)
  );

  pgcopy_ram #(
    .DEPTH (NUM_PAGES * PAGE_BYTES),
    .AW    (MEM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/pgcopy_chk.sv
module pgcopy_chk
  import pgcopy_pkg::*;
#(
  parameter int NUM_GRPS = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     busy,
  input logic                     done,
  input logic                     err,
  input logic                     ram_we,
  input logic [7:0]               ram_wdata,
  input logic [7:0]               ram_rdata,
  input logic [1:0]               mode_q,
  input logic [NUM_GRPS-1:0][1:0] modes
);

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !err)); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy)); // R5

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy); // R5

  AST_LOCK_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (mode_q != GM_LOCK)); // R5

  AST_EMUL_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && (mode_q == GM_EMUL)) |-> ((ram_wdata & ~ram_rdata) == 8'h00)); // R6

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_sticky
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(modes[g]) != GM_OPEN) |-> (modes[g] == $past(modes[g]))); // R9
  end

endmodule

bind pgcopy_unit pgcopy_chk #(
  .NUM_GRPS (NUM_GRPS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata),
  .ram_rdata (ram_rdata),
  .mode_q    (mode_q),
  .modes     (modes)
);

// File: tb/pgcopy_unit_tb.sv
`timescale 1ns/1ps
module pgcopy_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [11:0]  req_addr = '0;
  logic [255:0] req_data = '0;
  logic         mode_set_en = 1'b0;
  logic [3:0]   mode_set_grp = '0;
  logic [1:0]   mode_set_val = '0;
  logic [11:0]  rd_addr = '0;
  logic [7:0]   rd_data;
  logic         busy, done, err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pgcopy_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .mode_set_en(mode_set_en), .mode_set_grp(mode_set_grp), .mode_set_val(mode_set_val),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mkpat(int s);
    logic [255:0] p;
    for (int k = 0; k < 32; k++) p[8*k +: 8] = 8'(s * 29 + k * 13 + (k >> 2) * 71);
    return p;
  endfunction

  task automatic do_copy(input logic [11:0] a, input logic [255:0] d,
                         output int bc, output bit e, output bit d_seen);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    bc = 0; e = 1'b0; d_seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin e = err; d_seen = 1'b1; break; end
      if (busy) bc++;
      @(negedge clk);
    end
  endtask

  task automatic read_page(input int pg, output logic [255:0] v);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      rd_addr = {7'(pg), 5'(k)};
      @(negedge clk);
      v[8*k +: 8] = rd_data;
    end
  endtask

  task automatic set_mode(input int g, input logic [1:0] m);
    @(negedge clk);
    mode_set_en = 1'b1; mode_set_grp = 4'(g); mode_set_val = m;
    @(negedge clk);
    mode_set_en = 1'b0;
  endtask

  // Open copy that must succeed, with result verification
  task automatic open_copy(string req, int pg, logic [4:0] ofs, logic [255:0] d);
    int bc; bit e, ds; logic [255:0] v;
    do_copy({7'(pg), ofs}, d, bc, e, ds);
    chk(req, "done seen", 256'(ds), 256'(1));
    chk("R10", "busy cycles", 256'(bc), 256'(33));
    chk("R10", "err on success", 256'(e), 256'(0));
    read_page(pg, v);
    chk(req, "page after open copy", v, d);
  endtask

  task automatic t_reset;
    chk("R1", "busy", 256'(busy), 256'(0));
    chk("R1", "done", 256'(done), 256'(0));
    chk("R1", "err", 256'(err), 256'(0));
    chk("R1", "req_ready", 256'(req_ready), 256'(1));
  endtask

  task automatic t_open;
    open_copy("R3", 3, 5'h15, mkpat(1));       // nonzero offset ignored, byte lanes
    open_copy("R4", 3, 5'h00, mkpat(2));       // overwrite with unrelated image
    open_copy("R4", 79, 5'h1f, mkpat(3));      // last page, group 9
    open_copy("R11", 0, 5'h00, ~mkpat(4));     // page 0 read back via inspection port
  endtask

  task automatic t_emul;
    int bc; bit e, ds; logic [255:0] v, p, q, r;
    p = mkpat(5) | mkpat(6); q = mkpat(7); r = ~mkpat(8);
    open_copy("R4", 17, 5'h0, p);
    set_mode(2, 2'b10);
    do_copy({7'd17, 5'd0}, q, bc, e, ds);
    chk("R6", "err in erase-free", 256'(e), 256'(0));
    chk("R6", "busy cycles erase-free", 256'(bc), 256'(33));
    read_page(17, v);
    chk("R6", "first AND merge", v, p & q);
    do_copy({7'd17, 5'd9}, r, bc, e, ds);
    read_page(17, v);
    chk("R6", "second AND merge", v, p & q & r);
  endtask

  task automatic t_lock;
    int bc; bit e, ds; logic [255:0] v;
    open_copy("R4", 40, 5'h0, mkpat(9));
    set_mode(5, 2'b01);
    do_copy({7'd40, 5'd0}, mkpat(10), bc, e, ds);
    chk("R5", "err on locked copy", 256'(e), 256'(1));
    chk("R5", "busy never rises", 256'(bc), 256'(0));
    @(negedge clk);
    chk("R5", "done single pulse", 256'(done), 256'(0));
    read_page(40, v);
    chk("R5", "locked page untouched", v, mkpat(9));
  endtask

  task automatic t_sticky;
    int bc; bit e, ds; logic [255:0] v, cur;
    set_mode(5, 2'b00);
    do_copy({7'd41, 5'd0}, mkpat(11), bc, e, ds);
    chk("R9", "locked group stays locked", 256'(e), 256'(1));
    set_mode(2, 2'b01);
    read_page(18, cur);
    do_copy({7'd18, 5'd0}, mkpat(12), bc, e, ds);
    chk("R9", "erase-free group not relocked", 256'(e), 256'(0));
    read_page(18, v);
    chk("R9", "erase-free merge kept", v, cur & mkpat(12));
  endtask

  task automatic t_rsvd;
    set_mode(7, 2'b11);
    open_copy("R8", 60, 5'h0, mkpat(13));
    open_copy("R8", 60, 5'h0, ~mkpat(13));     // still open: bits rise again
  endtask

  task automatic t_range;
    int bc; bit e, ds;
    do_copy({7'd85, 5'd0}, mkpat(14), bc, e, ds);
    chk("R7", "page 85 refused", 256'(e), 256'(1));
    chk("R7", "page 85 no busy", 256'(bc), 256'(0));
    do_copy({7'd127, 5'd3}, mkpat(15), bc, e, ds);
    chk("R7", "page 127 refused", 256'(e), 256'(1));
  endtask

  task automatic t_busy_ignore;
    logic [255:0] v;
    int bc;
    open_copy("R4", 4, 5'h0, mkpat(16));
    @(negedge clk);
    req_valid = 1'b1; req_addr = {7'd5, 5'd0}; req_data = mkpat(17);
    @(negedge clk);
    req_valid = 1'b0;
    bc = 0;
    if (busy) bc++;
    chk("R2", "ready low while busy", 256'(req_ready), 256'(0));
    req_valid = 1'b1; req_addr = {7'd4, 5'd0}; req_data = mkpat(18);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (i == 3) req_valid = 1'b0;
      if (done) break;
      if (busy) bc++;
    end
    req_valid = 1'b0;
    chk("R2", "busy cycles unchanged", 256'(bc), 256'(33));
    @(negedge clk);
    chk("R2", "no second copy started", 256'(busy), 256'(0));
    read_page(4, v);
    chk("R2", "held request page untouched", v, mkpat(16));
    read_page(5, v);
    chk("R2", "accepted copy completed", v, mkpat(17));
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_emul();
    t_lock();
    t_sticky();
    t_rsvd();
    t_range();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule